// File: doc/BRIEF.md
# Idle-Gated Clearable Engine Status Registers

This block keeps two status registers for a coprocessor's execution engine and lets a host read them over a single-cycle register bus. The first is a sticky error register. It loads the engine's per-operation error vector on the cycle in which the engine signals completion, and it keeps that value until the next completion. The second is an executed-instruction counter. It advances once for every cycle in which an instruction executes without a stall.

A host write to either register clears it. The data written does not matter. The clear is accepted only while the engine is not busy executing, and a write made during execution is dropped without any effect. The counter is also forced to zero by an engine state-reset pulse and for as long as the engine is locked. Reads return the current value combinationally in the cycle of the read. A read of an address that maps to neither register returns zero and raises an error flag.

Top module: `exec_status_regs`

## Requirements
- R1: The error register loads the error vector only in a cycle where `eng_done_i` is high; in every other cycle it keeps its value.
- R2: A host write to the error register (word address 0) clears every bit to zero whatever `bus_wdata_i` holds, provided `eng_busy_i` is low.
- R3: A host write to either register while `eng_busy_i` is high leaves that register unchanged.
- R4: Read layout of the error register: vector bits 5..0 appear at bits 5..0, and vector bits 13..6 appear at bits 23..16. Every other bit reads as zero.
- R5: The counter (word address 1) increases by one in each cycle where `eng_insn_exec_i` is high and `eng_stall_i` is low, and holds otherwise.
- R6: The counter saturates at its all-ones value and never wraps.
- R7: The counter becomes zero after a cycle containing a state-reset pulse, a locked engine, or an accepted host write to the counter.
- R8: While `rst_ni` is low, both registers read zero, and this takes effect without waiting for a clock edge.
- R9: A clear beats a completion capture on the error register, and a clear beats an increment on the counter.
- R10: A read or write at any word address other than 0 or 1 returns zero on `bus_rdata_o` and drives `bus_err_o` high; mapped accesses keep `bus_err_o` low.
- R11: A value cleared by a host write is returned by a host read in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eng_busy_i | input | 1 | Engine is executing; blocks host clears |
| eng_done_i | input | 1 | Operation completion strobe |
| eng_locked_i | input | 1 | Engine is locked |
| eng_state_reset_i | input | 1 | Engine state-reset pulse |
| eng_insn_exec_i | input | 1 | An instruction is executing this cycle |
| eng_stall_i | input | 1 | The executing instruction is stalled |
| eng_err_i | input | 14 | Per-operation error vector |
| bus_addr_i | input | ADDR_W | Word address |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data (ignored) |
| bus_rdata_o | output | 32 | Read data |
| bus_err_o | output | 1 | Access to an unmapped address |

## Verification
Some properties are checked by assertions on every cycle. The error register holds its value outside completion cycles. A clear taken while idle empties it, and a write during execution leaves it alone. The counter never moves by more than one step, stays pinned once it reaches all-ones, and is zero after a locked cycle. Other behaviour only the bench scenarios can show. These include the bit placement of captured errors, the exact result when a clear and a capture or an increment arrive together, the response to unmapped addresses, saturation reached by a long run, and zero readback during an asynchronous reset.

// File: rtl/exec_status_regs.sv
module exec_status_regs #(
  parameter int ADDR_W   = 4,
  parameter int CNT_W    = 32,
  parameter int LO_W     = 6,
  parameter int HI_W     = 8,
  parameter int HI_POS   = 16,
  parameter int ERR_ADDR = 0,
  parameter int CNT_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic              eng_locked_i,
  input  logic              eng_state_reset_i,
  input  logic              eng_insn_exec_i,
  input  logic              eng_stall_i,
  input  logic [13:0]       eng_err_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_err_o
);
  localparam int ERR_W = LO_W + HI_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ERR_W-1:0] err_q;
  logic [CNT_W-1:0] cnt_q;
  logic hit_err, hit_cnt, err_clr, cnt_clr, cnt_step;
  logic [31:0] err_view;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata_i;

  assign hit_err  = (bus_addr_i == ADDR_W'(ERR_ADDR));
  assign hit_cnt  = (bus_addr_i == ADDR_W'(CNT_ADDR));
  assign err_clr  = bus_we_i & hit_err & ~eng_busy_i;
  assign cnt_clr  = eng_state_reset_i | eng_locked_i | (bus_we_i & hit_cnt & ~eng_busy_i);
  assign cnt_step = eng_insn_exec_i & ~eng_stall_i & (cnt_q != CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_q <= '0;
    else if (err_clr)     err_q <= '0;
    else if (eng_done_i)  err_q <= eng_err_i[ERR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cnt_clr)   cnt_q <= '0;
    else if (cnt_step)  cnt_q <= cnt_q + CNT_W'(1);
  end

  always_comb begin
    err_view = '0;
    err_view[LO_W-1:0] = err_q[LO_W-1:0];
    err_view[HI_POS +: HI_W] = err_q[ERR_W-1:LO_W];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      if (hit_err)      bus_rdata_o = err_view;
      else if (hit_cnt) bus_rdata_o = 32'(cnt_q);
    end
  end

  assign bus_err_o = (bus_re_i | bus_we_i) & ~hit_err & ~hit_cnt;

  assert_err_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eng_done_i && !(bus_we_i && hit_err)) |=> $stable(err_q));

  assert_err_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && hit_err && !eng_busy_i) |=> (err_q == '0));

  assert_busy_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && hit_err && eng_busy_i && !eng_done_i) |=> $stable(err_q));

  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0));

  assert_cnt_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || cnt_q == '0));

  assert_locked_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_locked_i |=> (cnt_q == '0));
endmodule

// File: tb/tb_exec_status_regs.sv
module tb_exec_status_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic busy = 0, done = 0, locked = 0, sreset = 0, exec = 0, stall = 0;
  logic [13:0] errv = '0;
  logic [AW-1:0] addr = '0;
  logic we = 0, re = 0;
  logic [31:0] wdata = '0, rdata;
  logic berr;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_status_regs #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .eng_busy_i(busy), .eng_done_i(done),
    .eng_locked_i(locked), .eng_state_reset_i(sreset), .eng_insn_exec_i(exec),
    .eng_stall_i(stall), .eng_err_i(errv), .bus_addr_i(addr), .bus_we_i(we),
    .bus_re_i(re), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(berr));

  // {done, write, busy, vec[13:0], expected[31:0]}
  localparam logic [48:0] VEC [0:8] = '{
    {1'b1, 1'b0, 1'b1, 14'h0001, 32'h0000_0001},
    {1'b0, 1'b0, 1'b1, 14'h3FFF, 32'h0000_0001},
    {1'b1, 1'b0, 1'b0, 14'h0040, 32'h0001_0000},
    {1'b0, 1'b1, 1'b1, 14'h0000, 32'h0001_0000},
    {1'b0, 1'b1, 1'b0, 14'h0000, 32'h0000_0000},
    {1'b1, 1'b0, 1'b0, 14'h3FFF, 32'h00FF_003F},
    {1'b1, 1'b1, 1'b0, 14'h0020, 32'h0000_0000},
    {1'b1, 1'b1, 1'b1, 14'h2000, 32'h0080_0000},
    {1'b1, 1'b0, 1'b0, 14'h0020, 32'h0000_0020}
  };
  localparam string VREQ [0:8] = '{"R1", "R1", "R4", "R3", "R2", "R4", "R9", "R3", "R4"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic e);
    addr = AW'(a); re = 1; #1;
    d = rdata; e = berr;
    re = 0;
  endtask

  task automatic wr_now(input int a, input logic [31:0] d);
    addr = AW'(a); wdata = d; we = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, d, e); chk("R8 err after reset", d, 32'h0);
    rd(1, d, e); chk("R8 cnt after reset", d, 32'h0);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      done = VEC[i][48]; we = VEC[i][47]; busy = VEC[i][46]; errv = VEC[i][45:32];
      addr = AW'(0); wdata = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h1234_0000;
      @(negedge clk);
      done = 0; we = 0; busy = 0; errv = '0;
      rd(0, d, e); chk(VREQ[i], d, VEC[i][31:0]);
    end

    // R5: counting with stalls
    @(negedge clk); busy = 1; exec = 1;
    repeat (5) @(negedge clk);
    stall = 1;
    repeat (3) @(negedge clk);
    exec = 0; stall = 0;
    rd(1, d, e); chk("R5 count", d, 32'd5);
    // R3: busy write to counter ignored
    wr_now(1, 32'h0); @(negedge clk); we = 0;
    rd(1, d, e); chk("R3 busy cnt write", d, 32'd5);
    // R7/R11: idle write clears, visible next cycle
    busy = 0; wr_now(1, 32'hDEAD_BEEF); @(negedge clk); we = 0;
    rd(1, d, e); chk("R11 cnt cleared", d, 32'd0);
    // R7: state reset pulse
    exec = 1; repeat (4) @(negedge clk); exec = 0;
    rd(1, d, e); chk("R5 recount", d, 32'd4);
    sreset = 1; @(negedge clk); sreset = 0;
    rd(1, d, e); chk("R7 state reset", d, 32'd0);
    // R7: locked
    exec = 1; repeat (3) @(negedge clk);
    locked = 1; @(negedge clk);
    rd(1, d, e); chk("R7 locked", d, 32'd0);
    @(negedge clk);
    rd(1, d, e); chk("R7 still locked", d, 32'd0);
    locked = 0; exec = 0;
    // R9: clear beats increment
    exec = 1; repeat (2) @(negedge clk);
    wr_now(1, 32'h0); @(negedge clk); we = 0; exec = 0;
    rd(1, d, e); chk("R9 clear over increment", d, 32'd0);
    // R6: saturation
    exec = 1; repeat (300) @(negedge clk);
    rd(1, d, e); chk("R6 saturated", d, 32'd255);
    @(negedge clk); exec = 0;
    rd(1, d, e); chk("R6 no wrap", d, 32'd255);
    // R10: unmapped address
    rd(3, d, e); chk("R10 unmapped data", d, 32'h0); chk("R10 unmapped flag", 32'(e), 32'd1);
    rd(1, d, e); chk("R10 mapped flag", 32'(e), 32'd0);
    addr = AW'(7); we = 1; #1; chk("R10 unmapped write flag", 32'(berr), 32'd1); we = 0;
    // R8: asynchronous reset mid-cycle
    @(negedge clk); done = 1; errv = 14'h0003; @(negedge clk); done = 0;
    rd(0, d, e); chk("R4 pre-reset capture", d, 32'h0000_0003);
    #2 rst_n = 0; #1;
    rd(0, d, e); chk("R8 async err", d, 32'h0);
    rd(1, d, e); chk("R8 async cnt", d, 32'h0);
    @(negedge clk); rst_n = 1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule